// File: doc/BRIEF.md
# Reference Loss and Lock-Wait Controller

This block decides when a bank of PLLs may run and when their outputs may leave the chip. It watches a fast reference clock from a slow, independent timebase. It also takes a supply-good flag that an analog comparator has already reduced to a single digital bit. While the reference is too slow or absent, or the supply is not good, the PLLs are held powered down and the outputs stay gated.

Once both conditions are good, the block releases the PLLs. It then counts out a fixed lock interval in timebase cycles and only after that enables the outputs. A change of any frequency select that retunes a PLL gates the outputs again and restarts the same interval. The PLLs stay powered during that restart.

The reference is measured without a fast clock on the timebase side. A prescaler in the reference domain divides the edges down. Its top bit is brought across by a synchronizer, and its transitions are counted over a fixed timebase window. The count is compared with a programmable minimum. The nominal reference is 54 MHz, and the validity limit corresponds to about 5 MHz.

Top module: `reflock_ctrl`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it, `pll_pwrdn_o` is 1, `out_en_o` is 0 and `ref_ok_o` is 0.
- R2: `ref_ok_o` is updated once every `WIN_CYC` timebase cycles. It is 1 when the number of prescaled reference transitions seen in that window (one transition per 2^(`REF_DIV_W`-1) reference edges) is at least `min_edges_i`, and 0 otherwise.
- R3: While `ref_ok_o` is 0, `pll_pwrdn_o` is 1 from the next cycle on and `out_en_o` never rises.
- R4: While the synchronized supply flag is low, `pll_pwrdn_o` is 1. A fall of `supply_ok_i` forces `pll_pwrdn_o` to 1 and `out_en_o` to 0 on the third clock edge after it, through a two-stage synchronizer.
- R5: When `ref_ok_o` and the supply are both good, `pll_pwrdn_o` drops. `out_en_o` rises exactly `LOCK_CYC` cycles after `pll_pwrdn_o` fell, provided no select change intervenes.
- R6: `out_en_o` is never 1 while `pll_pwrdn_o` is 1.
- R7: A change of `tune_sel_i` while `out_en_o` is 1 drops `out_en_o` on the next edge and keeps `pll_pwrdn_o` at 0. `out_en_o` returns `LOCK_CYC` cycles later.
- R8: A change of `tune_sel_i` during the lock wait restarts it. `out_en_o` rises `LOCK_CYC` cycles after the last change.
- R9: When the reference slows below the threshold while running, `pll_pwrdn_o` rises within two windows.
- R10: Raising `min_edges_i` above the measured count makes `ref_ok_o` fall within two windows and powers the PLLs down. Restoring it lets the start-up sequence run again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Slow timebase clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock under watch, asynchronous to clk_i |
| supply_ok_i | input | 1 | Supply-good flag from the comparator, asynchronous |
| min_edges_i | input | CNT_W | Minimum prescaled transitions per window for a valid reference |
| tune_sel_i | input | SEL_W | Frequency selects; any change retunes a PLL |
| ref_ok_o | output | 1 | Reference judged valid in the last window |
| pll_pwrdn_o | output | 1 | PLL power-down request |
| out_en_o | output | 1 | Clock output enable |

## Verification
The bench targets the length of the lock wait: a counter off by one would make `out_en_o` rise a cycle early or late. It restarts the wait in mid-count with a second select change; a design that ignored the restart would enable the outputs 100 cycles too soon. It drops the supply while running, where a missing or extra synchronizer stage shifts the power-down by a cycle. It slows, and then starts again, the reference and raises the threshold, to catch a meter that compares the wrong way or never clears its count, since either would leave the outputs enabled on a dead reference.

// File: rtl/rlc_pkg.sv
`timescale 1ns/1ps
// Shared types for the reference loss and lock-wait controller.
package rlc_pkg;
    // Controller states; outputs are gated in every state but RUN.
    typedef enum logic [1:0] {
        ST_PWRDN = 2'd0,
        ST_WAIT  = 2'd1,
        ST_RUN   = 2'd2
    } rlc_state_e;
endpackage

// File: rtl/rlc_bit_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for one asynchronous level.
// Assumes: the input is a level or toggle that holds for at least two
// destination cycles; the reset value is 0.
module rlc_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rlc_ref_prescale.sv
`timescale 1ns/1ps
// Free-running counter in the reference clock domain. Its top bit
// changes once per 2^(DIV_W-1) reference edges, slow enough for the
// timebase to sample.
// Assumes: the reference runs while reset is low, so the counter leaves X;
// its absolute value is otherwise irrelevant.
module rlc_ref_prescale #(
    parameter int DIV_W = 5
) (
    input  logic ref_clk_i,
    input  logic rst_ni,
    output logic div_msb_o
);
    logic [DIV_W-1:0] div_q;

    // Count reference edges.
    always_ff @(posedge ref_clk_i) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_q + 1'b1;
    end

    assign div_msb_o = div_q[DIV_W-1];
endmodule

// File: rtl/rlc_freq_meter.sv
`timescale 1ns/1ps
// Counts transitions of the synchronized prescaler bit over a fixed
// window of timebase cycles. At each window end it judges the reference
// valid when the count reaches the programmable minimum.
// Assumes: the prescaled bit changes slower than half the timebase rate.
module rlc_freq_meter #(
    parameter int WIN_CYC = 64,
    parameter int CNT_W   = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             div_msb_i,
    input  logic [CNT_W-1:0] min_edges_i,
    output logic             ref_ok_o
);
    localparam int WIN_W = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);

    logic             msb_sync;
    logic             msb_prev_q;
    logic             step;
    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;

    rlc_bit_sync #(.STAGES(2)) u_msb_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (div_msb_i),
        .q_o    (msb_sync)
    );

    // Remember the last synchronized level for transition detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) msb_prev_q <= 1'b0;
        else         msb_prev_q <= msb_sync;
    end

    assign step = msb_sync ^ msb_prev_q;

    // Saturating sum of this window's transitions including the present one.
    always_comb begin
        cnt_next = cnt_q;
        if (step && (cnt_q != '1)) cnt_next = cnt_q + 1'b1;
    end

    // Window counter, transition counter and the validity verdict.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            win_q    <= '0;
            cnt_q    <= '0;
            ref_ok_o <= 1'b0;
        end else if (win_q == WIN_LAST) begin
            win_q    <= '0;
            cnt_q    <= '0;
            ref_ok_o <= (cnt_next >= min_edges_i);
        end else begin
            win_q    <= win_q + 1'b1;
            cnt_q    <= cnt_next;
        end
    end
endmodule

// File: rtl/rlc_lock_fsm.sv
`timescale 1ns/1ps
// Power-down / lock-wait / run sequencer. Any loss of the reference or
// supply forces power-down at once. The lock wait is counted in timebase
// cycles and restarts when the select word changes.
// Assumes: tune_sel_i is synchronous to clk_i; ref_ok_i and sup_ok_i are
// already in the clk_i domain.
module rlc_lock_fsm
    import rlc_pkg::*;
#(
    parameter int LOCK_CYC = 5000,
    parameter int SEL_W    = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ref_ok_i,
    input  logic             sup_ok_i,
    input  logic [SEL_W-1:0] tune_sel_i,
    output logic             pll_pwrdn_o,
    output logic             out_en_o
);
    localparam int LK_W = (LOCK_CYC > 2) ? $clog2(LOCK_CYC) : 1;
    localparam logic [LK_W-1:0] LK_LAST = LK_W'(LOCK_CYC - 1);

    rlc_state_e       state_q, state_d;
    logic [LK_W-1:0]  lock_q, lock_d;
    logic [SEL_W-1:0] sel_q;
    logic             good;
    logic             retune;

    assign good   = ref_ok_i && sup_ok_i;
    assign retune = (tune_sel_i != sel_q);

    // Track the select word for change detection.
    always_ff @(posedge clk_i) begin
        sel_q <= tune_sel_i;
    end

    // Next-state and lock-counter decision.
    always_comb begin
        state_d = state_q;
        lock_d  = lock_q;
        unique case (state_q)
            ST_PWRDN: begin
                lock_d = '0;
                if (good) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!good) begin
                    state_d = ST_PWRDN;
                    lock_d  = '0;
                end else if (retune) begin
                    lock_d  = '0;
                end else if (lock_q == LK_LAST) begin
                    state_d = ST_RUN;
                    lock_d  = '0;
                end else begin
                    lock_d  = lock_q + 1'b1;
                end
            end
            ST_RUN: begin
                lock_d = '0;
                if (!good)       state_d = ST_PWRDN;
                else if (retune) state_d = ST_WAIT;
            end
            default: begin
                state_d = ST_PWRDN;
                lock_d  = '0;
            end
        endcase
    end

    // State, counter and registered control outputs.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q     <= ST_PWRDN;
            lock_q      <= '0;
            pll_pwrdn_o <= 1'b1;
            out_en_o    <= 1'b0;
        end else begin
            state_q     <= state_d;
            lock_q      <= lock_d;
            pll_pwrdn_o <= (state_d == ST_PWRDN);
            out_en_o    <= (state_d == ST_RUN);
        end
    end
endmodule

// File: rtl/reflock_ctrl.sv
`timescale 1ns/1ps
// Top level: reference frequency check, supply gate and lock-wait
// sequencing for a PLL bank.
// Assumes: clk_i is a free-running timebase independent of ref_clk_i and
// more than twice as fast as the prescaled reference bit toggles.
module reflock_ctrl #(
    parameter int REF_DIV_W = 5,
    parameter int WIN_CYC   = 64,
    parameter int CNT_W     = 8,
    parameter int LOCK_CYC  = 5000,
    parameter int SEL_W     = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ref_clk_i,
    input  logic             supply_ok_i,
    input  logic [CNT_W-1:0] min_edges_i,
    input  logic [SEL_W-1:0] tune_sel_i,
    output logic             ref_ok_o,
    output logic             pll_pwrdn_o,
    output logic             out_en_o
);
    logic div_msb;
    logic sup_ok;

    rlc_ref_prescale #(.DIV_W(REF_DIV_W)) u_prescale (
        .ref_clk_i (ref_clk_i),
        .rst_ni    (rst_ni),
        .div_msb_o (div_msb)
    );

    rlc_freq_meter #(.WIN_CYC(WIN_CYC), .CNT_W(CNT_W)) u_meter (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .div_msb_i   (div_msb),
        .min_edges_i (min_edges_i),
        .ref_ok_o    (ref_ok_o)
    );

    rlc_bit_sync #(.STAGES(2)) u_sup_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (supply_ok_i),
        .q_o    (sup_ok)
    );

    rlc_lock_fsm #(.LOCK_CYC(LOCK_CYC), .SEL_W(SEL_W)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ref_ok_i    (ref_ok_o),
        .sup_ok_i    (sup_ok),
        .tune_sel_i  (tune_sel_i),
        .pll_pwrdn_o (pll_pwrdn_o),
        .out_en_o    (out_en_o)
    );
endmodule

// File: rtl/reflock_ctrl_chk.sv
`timescale 1ns/1ps
// Port-level property checker for reflock_ctrl, attached by bind.
module reflock_ctrl_chk #(
    parameter int LOCK_CYC = 5000,
    parameter int SEL_W    = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             supply_ok_i,
    input logic [SEL_W-1:0] tune_sel_i,
    input logic             ref_ok_o,
    input logic             pll_pwrdn_o,
    input logic             out_en_o
);
    localparam int QW = $clog2(LOCK_CYC + 2) + 1;

    logic [SEL_W-1:0] sel_prev;
    logic             sel_chg;
    logic [QW-1:0]    quiet_q;
    logic [1:0]       low_q;

    assign sel_chg = (tune_sel_i != sel_prev);

    // Previous select word seen at the port.
    always_ff @(posedge clk_i) sel_prev <= tune_sel_i;

    // Cycles spent powered up but gated, with no select change.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                               quiet_q <= '0;
        else if (pll_pwrdn_o || out_en_o || sel_chg) quiet_q <= '0;
        else if (quiet_q != '1)                    quiet_q <= quiet_q + 1'b1;
    end

    // Consecutive sampled cycles with the supply flag low (saturates at 3).
    always_ff @(posedge clk_i) begin
        if (!rst_ni)          low_q <= '0;
        else if (supply_ok_i) low_q <= '0;
        else if (low_q != 2'd3) low_q <= low_q + 1'b1;
    end

    assert_reset_state_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (pll_pwrdn_o && !out_en_o && !ref_ok_o));

    assert_bad_ref_pwrdn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ref_ok_o |=> pll_pwrdn_o);

    assert_supply_pwrdn_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (low_q == 2'd3) |-> (pll_pwrdn_o && !out_en_o));

    assert_lock_wait_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(out_en_o) |-> (quiet_q == QW'(LOCK_CYC)));

    assert_en_excl_pwrdn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(out_en_o && pll_pwrdn_o));

    assert_retune_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_en_o && sel_chg) |=> !out_en_o);
endmodule

bind reflock_ctrl reflock_ctrl_chk #(.LOCK_CYC(LOCK_CYC), .SEL_W(SEL_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .tune_sel_i  (tune_sel_i),
    .ref_ok_o    (ref_ok_o),
    .pll_pwrdn_o (pll_pwrdn_o),
    .out_en_o    (out_en_o)
);

// File: tb/reflock_ctrl_tb.sv
`timescale 1ns/1ps
module reflock_ctrl_tb;
    localparam int CLK_PERIOD = 100;
    localparam int WIN  = 64;
    localparam int LOCK = 300;
    localparam int CW   = 8;
    localparam int SW   = 3;

    typedef struct {
        logic  pd;
        logic  en;
        int    gmin;
        int    gmax;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_clk = 1'b0;
    logic          supply = 1'b0;
    logic [CW-1:0] min_e = 8'd8;
    logic [SW-1:0] sel = '0;
    logic          ref_ok, pwrdn, en;

    int  ref_half = 9;
    bit  ref_on = 1'b1;
    int  cyc = 0;
    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    exp_t q[$];

    reflock_ctrl #(.REF_DIV_W(5), .WIN_CYC(WIN), .CNT_W(CW),
                   .LOCK_CYC(LOCK), .SEL_W(SW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .supply_ok_i(supply),
        .min_edges_i(min_e), .tune_sel_i(sel),
        .ref_ok_o(ref_ok), .pll_pwrdn_o(pwrdn), .out_en_o(en));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always begin
        if (ref_on) #(ref_half) ref_clk = ~ref_clk;
        else        #(50);
    end

    task automatic check(input string tag, input logic act, input logic expv, input string what);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, what, act, expv, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_evt(input logic pd, input logic e, input int gmin, input int gmax, input string tag);
        exp_t it;
        it.pd = pd; it.en = e; it.gmin = gmin; it.gmax = gmax; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic drain();
        while (q.size() != 0) step(1);
        step(5);
    endtask

    // Monitor: every change of the control pair is matched against the queue.
    logic [1:0] last = 2'b10;
    int last_cyc = 0;
    always @(negedge clk) begin
        if (rst_n && !done && ({pwrdn, en} !== last)) begin
            exp_t it;
            int gap;
            gap = cyc - last_cyc;
            n_chk++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected event: actual pd=%b en=%b expected no change at cycle %0d",
                         pwrdn, en, cyc);
            end else begin
                it = q.pop_front();
                if (pwrdn !== it.pd || en !== it.en || gap < it.gmin ||
                    (it.gmax >= 0 && gap > it.gmax)) begin
                    n_bad++;
                    $display("FAIL %s event: actual pd=%b en=%b gap=%0d expected pd=%b en=%b gap %0d..%0d",
                             it.tag, pwrdn, en, gap, it.pd, it.en, it.gmin, it.gmax);
                end
            end
            last = {pwrdn, en};
            last_cyc = cyc;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * CLK_PERIOD);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        step(3);
        check("R1", pwrdn, 1'b1, "pwrdn in reset");
        check("R1", en, 1'b0, "en in reset");
        check("R1", ref_ok, 1'b0, "ref_ok in reset");
        rst_n = 1'b1;
        step(1);
        check("R1", pwrdn, 1'b1, "pwrdn after reset");

        // R2 and R4: fast reference validated, supply still low
        step(3 * WIN);
        check("R2", ref_ok, 1'b1, "fast ref valid");
        check("R4", pwrdn, 1'b1, "pwrdn with supply low");
        check("R4", en, 1'b0, "en with supply low");

        // R5: start-up lock wait
        expect_evt(1'b0, 1'b0, 0, -1, "R5");
        expect_evt(1'b0, 1'b1, LOCK, LOCK, "R5");
        supply = 1'b1;
        drain();
        check("R6", pwrdn, 1'b0, "pwrdn while running");

        // R7: select change while running
        expect_evt(1'b0, 1'b0, 0, -1, "R7");
        expect_evt(1'b0, 1'b1, LOCK, LOCK, "R7");
        sel = 3'd1;
        step(1);
        check("R7", en, 1'b0, "en gated after retune");
        check("R7", pwrdn, 1'b0, "pll kept powered on retune");
        drain();

        // R8: second change during the wait restarts it
        expect_evt(1'b0, 1'b0, 0, -1, "R8");
        expect_evt(1'b0, 1'b1, 100 + LOCK, 100 + LOCK, "R8");
        sel = 3'd2;
        step(100);
        sel = 3'd5;
        drain();

        // R4: supply drop while running, then recovery
        expect_evt(1'b1, 1'b0, 0, -1, "R4");
        supply = 1'b0;
        step(2);
        check("R4", en, 1'b1, "en before sync latency");
        step(1);
        check("R4", en, 1'b0, "en after supply loss");
        check("R4", pwrdn, 1'b1, "pwrdn after supply loss");
        drain();
        expect_evt(1'b0, 1'b0, 0, -1, "R5");
        expect_evt(1'b0, 1'b1, LOCK, LOCK, "R5");
        supply = 1'b1;
        drain();

        // R10: threshold above measured count
        expect_evt(1'b1, 1'b0, 0, 2 * WIN + 4, "R10");
        min_e = 8'd200;
        drain();
        check("R10", ref_ok, 1'b0, "ref invalid with high minimum");
        expect_evt(1'b0, 1'b0, 0, -1, "R10");
        expect_evt(1'b0, 1'b1, LOCK, LOCK, "R10");
        min_e = 8'd8;
        drain();

        // R9: reference slows below threshold while running
        expect_evt(1'b1, 1'b0, 0, 2 * WIN + 4, "R9");
        ref_half = 200;
        drain();
        check("R9", ref_ok, 1'b0, "slow ref invalid");

        // R3: outputs stay off on a slow, then stopped, reference
        step(LOCK + 3 * WIN);
        check("R3", pwrdn, 1'b1, "pwrdn on slow ref");
        check("R3", en, 1'b0, "en on slow ref");
        ref_on = 1'b0;
        step(3 * WIN);
        check("R3", pwrdn, 1'b1, "pwrdn on stopped ref");
        check("R3", ref_ok, 1'b0, "stopped ref invalid");

        // R5: reference returns
        expect_evt(1'b0, 1'b0, 0, -1, "R5");
        expect_evt(1'b0, 1'b1, LOCK, LOCK, "R5");
        ref_half = 9;
        ref_on = 1'b1;
        drain();
        check("R5", en, 1'b1, "outputs back after ref returns");
        n_chk++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R5 pending events: actual %0d expected 0", q.size());
        end
        finish_run();
    end
endmodule